// File: doc/BRIEF.md
# Defect List Sector Parser

This block reads the data field of a defect-list sector as a byte stream and turns it into structured results. The 256-byte field begins with a short header that records when and where the list was made. A series of fixed-size defect records follows. Each record names a cylinder, a byte position measured from the index mark, and the length of the flaw in bits. Two check bytes follow the field. The block pulls out the header, emits one strobe per record, stops at the all-ones end marker, and checks the field against its CRC.

Bytes arrive on `in_byte` in each cycle in which `in_valid` is high. `in_last` marks the final check byte. Results are held on the outputs until the first byte of the next sector arrives.

Top module: `dlist_parse`

## Requirements
- R1: After reset, `rec_valid`, `list_end`, `overflow`, `done` and `crc_error` are low, `rec_count` is 0, and the four header outputs are 0.
- R2: Bytes 0, 1, 2 and 3 of a sector load `hdr_month`, `hdr_day`, `hdr_year` and `hdr_head` respectively. Bytes 4 and 5 are padding and change no output.
- R3: Records start at byte 6 and are 5 bytes long. The bytes of a record are, in order: cylinder high, cylinder low, offset high, offset low, flaw length. For each record that is not a terminator, `rec_valid` is high for exactly one cycle, in the cycle after the record's fifth byte is accepted. In that same cycle `rec_cyl`, `rec_offset` and `rec_len` carry the record and `rec_count` has gone up by one.
- R4: A record whose five bytes are all 0xFF produces no strobe and sets `list_end`. Every record after it in the field is ignored, even one that is not all ones.
- R5: Record parsing covers only bytes 6 to FIELD_BYTES-1. If the field ends without a terminator, `list_end` stays low, and the check bytes are never taken as record bytes.
- R6: At most MAX_RECS strobes are issued per sector. A further record that is not a terminator sets `overflow` and produces no strobe.
- R7: The CRC uses the polynomial 0x1021, starts at 0xFFFF, and feeds the data bits MSB first over all FIELD_BYTES data bytes, terminator and fill included. The check bytes follow, high byte first. When the byte marked by `in_last` is accepted, `done` rises in the next cycle, and `crc_error` rises with it if the check bytes do not match.
- R8: A cycle with `in_valid` low is ignored: no byte is consumed and the parse position does not advance.
- R9: The first accepted byte after `done` starts a new sector. It clears `done`, `crc_error`, `list_end`, `overflow` and `rec_count`, and is taken as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final check byte |
| hdr_month | output | 8 | Header byte 0 |
| hdr_day | output | 8 | Header byte 1 |
| hdr_year | output | 8 | Header byte 2 |
| hdr_head | output | 8 | Header byte 3 |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_cyl | output | 16 | Cylinder of the record |
| rec_offset | output | 16 | Byte offset from index of the record |
| rec_len | output | 8 | Flaw length in bits |
| rec_count | output | clog2(MAX_RECS+1) | Records emitted in this sector |
| list_end | output | 1 | Terminator seen |
| overflow | output | 1 | Record beyond the cap was dropped |
| done | output | 1 | Sector complete |
| crc_error | output | 1 | Check bytes did not match |

## Verification
The bench sends four sectors and compares each against a behavioural model on every clock.

- The first sector has a few records, its terminator and the 0xFF fill, with idle cycles mixed in. It tells correct stall handling apart from position slips.
- The second sector has a record made mostly of 0xFF bytes, a real terminator, a non-ones record after the terminator, and a corrupted check byte. It separates a true terminator from a near miss and shows that records after the terminator are ignored.
- The third sector starts with a terminator and arrives straight after a failed sector. It shows that all flags clear on the first new byte.
- The last sector fills the field with records and no terminator, using a record cap below the field's capacity. It exercises the end-of-field stop and overflow suppression.

// File: rtl/dlist_parse.sv
module dlist_parse #(
  parameter int FIELD_BYTES = 256,
  parameter int HDR_BYTES   = 6,
  parameter int MAX_RECS    = 50,
  localparam int PW = $clog2(FIELD_BYTES + 3),
  localparam int CW = $clog2(MAX_RECS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  output logic [7:0]    hdr_month,
  output logic [7:0]    hdr_day,
  output logic [7:0]    hdr_year,
  output logic [7:0]    hdr_head,
  output logic          rec_valid,
  output logic [15:0]   rec_cyl,
  output logic [15:0]   rec_offset,
  output logic [7:0]    rec_len,
  output logic [CW-1:0] rec_count,
  output logic          list_end,
  output logic          overflow,
  output logic          done,
  output logic          crc_error
);
  localparam logic [PW-1:0] HDR_P = PW'(HDR_BYTES);
  localparam logic [PW-1:0] END_P = PW'(FIELD_BYTES);
  localparam logic [CW-1:0] CAP   = CW'(MAX_RECS);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  logic [PW-1:0] pos;
  logic [2:0]    slot;
  logic [31:0]   acc;
  logic [15:0]   crc;

  wire [15:0] crc_nx   = crc_step(crc, in_byte);
  wire        in_recs  = (pos >= HDR_P) && (pos < END_P);
  wire        take     = in_valid && in_recs && !list_end;
  wire        rec_done = take && (slot == 3'd4);
  wire        term     = (acc == 32'hFFFF_FFFF) && (in_byte == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; slot <= '0; acc <= '0; crc <= 16'hFFFF;
      hdr_month <= '0; hdr_day <= '0; hdr_year <= '0; hdr_head <= '0;
      rec_valid <= 1'b0; rec_cyl <= '0; rec_offset <= '0; rec_len <= '0;
      rec_count <= '0; list_end <= 1'b0; overflow <= 1'b0;
      done <= 1'b0; crc_error <= 1'b0;
    end else begin
      rec_valid <= 1'b0;
      if (in_valid) begin
        if (done) begin
          done <= 1'b0; crc_error <= 1'b0; list_end <= 1'b0;
          overflow <= 1'b0; rec_count <= '0;
        end
        case (pos)
          PW'(0): hdr_month <= in_byte;
          PW'(1): hdr_day   <= in_byte;
          PW'(2): hdr_year  <= in_byte;
          PW'(3): hdr_head  <= in_byte;
          default: ;
        endcase
        if (take) begin
          slot <= rec_done ? 3'd0 : slot + 3'd1;
          acc  <= {acc[23:0], in_byte};
        end
        if (rec_done) begin
          if (term) list_end <= 1'b1;
          else if (rec_count < CAP) begin
            rec_valid  <= 1'b1;
            rec_cyl    <= acc[31:16];
            rec_offset <= acc[15:0];
            rec_len    <= in_byte;
            rec_count  <= rec_count + 1'b1;
          end else overflow <= 1'b1;
        end
        if (in_last) begin
          done      <= 1'b1;
          crc_error <= (crc_nx != 16'h0000);
          pos       <= '0;
          slot      <= '0;
          crc       <= 16'hFFFF;
        end else begin
          pos <= (pos == '1) ? pos : pos + 1'b1;
          crc <= crc_nx;
        end
      end
    end
  end

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);
  p_quiet_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (list_end && $past(list_end)) |-> !rec_valid);
  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CAP);
  p_overflow_at_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (rec_count == CAP));
  p_done_from_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_last));
  p_crc_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |-> done);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(rec_count) && !rec_valid && $stable(hdr_month)));
endmodule

// File: tb/test_dlist_parse.sv
module test_dlist_parse;
  localparam int MR = 48;
  localparam int CW = $clog2(MR + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] hdr_month, hdr_day, hdr_year, hdr_head, rec_len;
  logic rec_valid, list_end, overflow, done, crc_error;
  logic [15:0] rec_cyl, rec_offset;
  logic [CW-1:0] rec_count;

  dlist_parse #(.MAX_RECS(MR)) i_dlist_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .hdr_month(hdr_month), .hdr_day(hdr_day), .hdr_year(hdr_year), .hdr_head(hdr_head),
    .rec_valid(rec_valid), .rec_cyl(rec_cyl), .rec_offset(rec_offset), .rec_len(rec_len),
    .rec_count(rec_count), .list_end(list_end), .overflow(overflow), .done(done),
    .crc_error(crc_error));

  always #2 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit ended = 0;
  logic [7:0] fr [258];
  bit cur_bad = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pos = 0, m_cnt = 0;
  logic [7:0] q [$];
  logic [7:0] m_mon = 0, m_day = 0, m_yr = 0, m_hd = 0, m_len = 0;
  logic [15:0] m_cyl = 0, m_off = 0;
  bit m_rv = 0, m_end = 0, m_ovf = 0, m_done = 0, m_crc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_cnt = 0; q.delete();
      m_mon = 0; m_day = 0; m_yr = 0; m_hd = 0;
      m_rv = 0; m_end = 0; m_ovf = 0; m_done = 0; m_crc = 0;
    end else begin
      m_rv = 0;
      if (in_valid) begin
        if (m_done) begin
          m_done = 0; m_crc = 0; m_end = 0; m_ovf = 0; m_cnt = 0; q.delete();
        end
        if (m_pos == 0) m_mon = in_byte;
        if (m_pos == 1) m_day = in_byte;
        if (m_pos == 2) m_yr  = in_byte;
        if (m_pos == 3) m_hd  = in_byte;
        if (m_pos >= 6 && m_pos < 256 && !m_end) begin
          q.push_back(in_byte);
          if (q.size() == 5) begin
            if ((q[0] & q[1] & q[2] & q[3] & q[4]) == 8'hFF) m_end = 1;
            else if (m_cnt < MR) begin
              m_rv = 1; m_cnt++;
              m_cyl = {q[0], q[1]}; m_off = {q[2], q[3]}; m_len = q[4];
            end else m_ovf = 1;
            q.delete();
          end
        end
        if (in_last) begin m_done = 1; m_crc = cur_bad; m_pos = 0; end
        else m_pos++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R2", "hdr_month", hdr_month, m_mon);
      chk("R2", "hdr_day", hdr_day, m_day);
      chk("R2", "hdr_year", hdr_year, m_yr);
      chk("R2", "hdr_head", hdr_head, m_hd);
      chk("R3", "rec_valid", rec_valid, m_rv);
      chk("R3", "rec_count", rec_count, m_cnt);
      if (m_rv) begin
        chk("R3", "rec_cyl", rec_cyl, m_cyl);
        chk("R3", "rec_offset", rec_offset, m_off);
        chk("R3", "rec_len", rec_len, m_len);
      end
      chk("R4", "list_end", list_end, m_end);
      chk("R6", "overflow", overflow, m_ovf);
      chk("R7", "done", done, m_done);
      chk("R7", "crc_error", crc_error, m_crc);
    end
  end

  function automatic logic [15:0] ref_crc();
    int c = 16'hFFFF;
    for (int i = 0; i < 256; i++) begin
      c = c ^ (int'(fr[i]) << 8);
      for (int b = 0; b < 8; b++)
        c = (c & 16'h8000) ? (((c << 1) ^ 16'h1021) & 16'hFFFF) : ((c << 1) & 16'hFFFF);
    end
    return c[15:0];
  endfunction

  task automatic hdr(input logic [7:0] mo, dy, yr, hd);
    for (int i = 0; i < 256; i++) fr[i] = 8'hFF;
    fr[0] = mo; fr[1] = dy; fr[2] = yr; fr[3] = hd; fr[4] = 8'h00; fr[5] = 8'h00;
  endtask

  task automatic put_rec(input int k, input logic [15:0] cyl, off, input logic [7:0] len);
    fr[6+5*k] = cyl[15:8]; fr[7+5*k] = cyl[7:0];
    fr[8+5*k] = off[15:8]; fr[9+5*k] = off[7:0]; fr[10+5*k] = len;
  endtask

  task automatic seal(input bit bad);
    logic [15:0] c;
    c = ref_crc();
    fr[256] = c[15:8];
    fr[257] = c[7:0] ^ (bad ? 8'h01 : 8'h00);
    cur_bad = bad;
  endtask

  task automatic drive(input int lo, input int hi, input int stall);
    for (int i = lo; i <= hi; i++) begin
      if (stall > 0 && (i % stall) == stall - 1) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_byte = fr[i]; in_last = (i == 257);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "rec_count", rec_count, 0);
    chk("R1", "flags", {rec_valid, list_end, overflow, done, crc_error}, 0);
    chk("R1", "header", {hdr_month, hdr_day, hdr_year, hdr_head}, 0);
    rst_n = 1'b1;

    // sector A: three records, terminator, fill; stalls (R8)
    hdr(8'd11, 8'd28, 8'd84, 8'd3);
    put_rec(0, 16'h0123, 16'h0456, 8'd7);
    put_rec(1, 16'h0200, 16'h1FFF, 8'd12);
    put_rec(2, 16'h07FF, 16'h0010, 8'd1);
    seal(0);
    drive(0, 257, 3);
    chk("R8", "rec_count after stalled sector", rec_count, 3);
    chk("R4", "list_end", list_end, 1);
    chk("R7", "crc_error good", crc_error, 0);

    // sector B: near-terminator record, real terminator, ignored record, bad CRC
    hdr(8'd1, 8'd2, 8'd85, 8'd0);
    put_rec(0, 16'hFFFF, 16'hFFFF, 8'h00);
    put_rec(1, 16'h0001, 16'h0002, 8'd3);
    put_rec(2, 16'hFF00, 16'h00FF, 8'hFF);
    put_rec(3, 16'h1000, 16'h2000, 8'd4);
    put_rec(4, 16'h0FFF, 16'hFFFE, 8'd5);
    put_rec(6, 16'h1234, 16'h5678, 8'd9);
    seal(1);
    drive(0, 257, 0);
    chk("R4", "rec_count stops at terminator", rec_count, 5);
    chk("R7", "crc_error bad", crc_error, 1);

    // sector C: immediate terminator; flags clear on first byte (R9)
    hdr(8'd12, 8'd31, 8'd99, 8'd1);
    seal(0);
    drive(0, 0, 0);
    chk("R9", "done cleared", done, 0);
    chk("R9", "crc_error cleared", crc_error, 0);
    chk("R9", "rec_count cleared", rec_count, 0);
    chk("R9", "list_end cleared", list_end, 0);
    drive(1, 257, 0);
    chk("R4", "empty list count", rec_count, 0);

    // sector D: field full of records, no terminator, cap below capacity
    hdr(8'd6, 8'd15, 8'd86, 8'd2);
    for (int k = 0; k < 50; k++)
      put_rec(k, 16'(k * 3 + 1), 16'(k * 97), 8'(k + 1));
    seal(0);
    drive(0, 257, 5);
    chk("R5", "list_end without terminator", list_end, 0);
    chk("R6", "rec_count capped", rec_count, MR);
    chk("R6", "overflow", overflow, 1);
    chk("R7", "done", done, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule